// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock from a faster base clock. The ratio is built from two stages. A power-of-two prescaler is selected by an 8-bit code. A linear stage then divides by 1 to 16, selected by a 4-bit code. A double-data-rate mode halves the prescaler stage.

The output clock is a registered square wave in the base clock domain. A companion one-cycle pulse marks each rising edge, so downstream logic can stay on the base clock and use that pulse as an enable.

A new ratio is taken up only at the end of a full output period, which always ends in the low phase, so no shortened high or low phase is ever produced. A stable flag tells the controller when the output has run cleanly at the applied ratio for long enough to start traffic.

Top module: `sdclk_divider`

## Requirements
- R1: While reset is high and on the first cycle after it, `card_clk_o`, `card_rise_o` and `card_stable_o` are all 0.
- R2: In single-rate mode the output period is P*D base cycles. D is `div_code_i`+1. If the prescaler code is zero, P is 1. Otherwise P is 2^(b+1), where b is the index of the highest set bit of `pre_code_i` (bit 7 is the most significant bit).
- R3: In double-rate mode (`ddr_i`=1) P is 2^b, and a prescaler code of zero still gives P=1. D is unchanged.
- R4: A computed ratio of 1 is run as a ratio of 2.
- R5: Each period begins with floor(N/2) base cycles of `card_clk_o` high, followed by the remaining cycles low, where N is the applied ratio.
- R6: `card_rise_o` is high for exactly one cycle: the cycle in which `card_clk_o` changes from 0 to 1. It is never high at any other time.
- R7: While `clk_en_i` is 0, all three outputs are 0 from the next cycle on. Once enable is seen high, the first rising edge appears on the next cycle.
- R8: A changed ratio is adopted only at the end of the current period. The period in progress completes at the old ratio.
- R9: `card_stable_o` drops on the cycle after the ratio at the inputs differs from the applied ratio.
- R10: `card_stable_o` rises together with the third rising edge after an enable or after a ratio is adopted, that is, after two complete periods at that ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pre_code_i | input | 8 | Power-of-two prescaler code; the highest set bit is used |
| div_code_i | input | 4 | Linear divisor minus one |
| clk_en_i | input | 1 | Card clock enable |
| ddr_i | input | 1 | Double-rate mode; halves the prescaler stage |
| card_clk_o | output | 1 | Divided card clock, registered |
| card_rise_o | output | 1 | One-cycle pulse on each rising edge of the card clock |
| card_stable_o | output | 1 | Card clock has run two clean periods at the applied ratio |

## Verification
The hardest case to reach is a ratio change that comes and goes inside one long period. In that case the stable flag must fall at once. At the boundary, the old ratio must still be in force, and the flag must be able to recover without a restart.

The stimulus reaches this case in two ways. First, it selects the largest ratio (4096) and changes the codes deep inside that period, so the change waits thousands of cycles for the boundary. Second, it applies a ratio for a single cycle and then restores the previous one. A reference model steps through each base cycle and is compared with all three outputs on every clock.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int PRE_W  = 8;
  localparam int DIV_W  = 4;
  localparam int RAT_W  = PRE_W + DIV_W + 1;
  localparam int SETTLE = 2;
endpackage

// File: rtl/sdclk_ratio.sv
module sdclk_ratio #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4,
  localparam int RAT_W = PRE_W + DIV_W + 1,
  localparam int SH_W  = $clog2(PRE_W + 2)
) (
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             ddr_i,
  output logic [RAT_W-1:0] ratio_o
);
  logic            hit;
  logic [SH_W-1:0] top_idx;
  logic [SH_W-1:0] shift;
  logic [RAT_W-1:0] lin;
  logic [RAT_W-1:0] full;

  // priority pick of the highest set prescaler bit (one-hot power of two)
  always_comb begin
    hit     = 1'b0;
    top_idx = '0;
    for (int i = PRE_W - 1; i >= 0; i--) begin
      if (!hit && pre_code_i[i]) begin
        hit     = 1'b1;
        top_idx = SH_W'(i);
      end
    end
    if (!hit)      shift = '0;
    else if (ddr_i) shift = top_idx;
    else           shift = top_idx + SH_W'(1);
    lin     = RAT_W'(div_code_i) + RAT_W'(1);
    full    = lin << shift;
    ratio_o = (full < RAT_W'(2)) ? RAT_W'(2) : full;
  end
endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase #(
  parameter int RAT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [RAT_W-1:0] ratio_i,
  output logic             card_clk_o,
  output logic             rise_o,
  output logic             run_o,
  output logic             at_end_o,
  output logic             mismatch_o
);
  logic             run_q;
  logic             clk_q;
  logic             rise_q;
  logic [RAT_W-1:0] pos_q;
  logic [RAT_W-1:0] ratio_q;

  assign at_end_o   = run_q && (pos_q == ratio_q - RAT_W'(1));
  assign mismatch_o = (ratio_i != ratio_q);
  assign run_o      = run_q;
  assign card_clk_o = clk_q;
  assign rise_o     = rise_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q   <= 1'b0;
      clk_q   <= 1'b0;
      rise_q  <= 1'b0;
      pos_q   <= '0;
      ratio_q <= RAT_W'(2);
    end else if (!en_i) begin
      run_q   <= 1'b0;
      clk_q   <= 1'b0;
      rise_q  <= 1'b0;
      pos_q   <= '0;
      ratio_q <= ratio_i;
    end else if (!run_q || at_end_o) begin
      // period boundary: the low phase has just ended, safe point to retarget
      run_q   <= 1'b1;
      clk_q   <= 1'b1;
      rise_q  <= 1'b1;
      pos_q   <= '0;
      ratio_q <= ratio_i;
    end else begin
      pos_q  <= pos_q + RAT_W'(1);
      clk_q  <= (pos_q + RAT_W'(1)) < (ratio_q >> 1);
      rise_q <= 1'b0;
    end
  end

  p_retarget_at_edge_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ratio_q != $past(ratio_q)) |-> (rise_q || !run_q));
  p_rise_marks_edge_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(clk_q) |-> rise_q);
  p_rise_after_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_q |-> !$past(clk_q));
endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle #(
  parameter int SETTLE = 2,
  localparam int PER_W = $clog2(SETTLE + 1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic run_i,
  input  logic at_end_i,
  input  logic mismatch_i,
  input  logic rise_i,
  output logic stable_o
);
  logic [PER_W-1:0] per_q;
  logic             stable_q;

  assign stable_o = stable_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i || !run_i) begin
      per_q    <= '0;
      stable_q <= 1'b0;
    end else if (at_end_i) begin
      if (mismatch_i) begin
        per_q    <= '0;
        stable_q <= 1'b0;
      end else begin
        if (int'(per_q) < SETTLE) per_q <= per_q + PER_W'(1);
        stable_q <= (int'(per_q) + 1 >= SETTLE);
      end
    end else begin
      stable_q <= stable_q && !mismatch_i;
    end
  end

  p_stable_with_edge_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(stable_q) |-> rise_i);
  p_pending_clears_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && mismatch_i) |=> !stable_q);
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             clk_en_i,
  input  logic             ddr_i,
  output logic             card_clk_o,
  output logic             card_rise_o,
  output logic             card_stable_o
);
  logic [RAT_W-1:0] ratio;
  logic run, at_end, mismatch;

  sdclk_ratio #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_ratio (
    .pre_code_i(pre_code_i), .div_code_i(div_code_i), .ddr_i(ddr_i),
    .ratio_o(ratio));

  sdclk_phase #(.RAT_W(RAT_W)) u_phase (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(clk_en_i), .ratio_i(ratio),
    .card_clk_o(card_clk_o), .rise_o(card_rise_o), .run_o(run),
    .at_end_o(at_end), .mismatch_o(mismatch));

  sdclk_settle #(.SETTLE(SETTLE)) u_settle (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(clk_en_i), .run_i(run),
    .at_end_i(at_end), .mismatch_i(mismatch), .rise_i(card_rise_o),
    .stable_o(card_stable_o));

  p_off_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !clk_en_i |=> (!card_clk_o && !card_rise_o && !card_stable_o));
endmodule

// File: tb/test_sdclk_divider.sv
`timescale 1ns/1ps
module test_sdclk_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pre = 8'h00;
  logic [3:0] dv  = 4'h0;
  logic       en  = 1'b0;
  logic       ddr = 1'b0;
  logic       card_clk, card_rise, card_stable;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";
  bit finished = 0;

  int m_run, m_n, m_pos, m_clk, m_rise, m_stable, m_per;

  always #2.5 clk = ~clk;

  sdclk_divider i_sdclk_divider (
    .clk_i(clk), .rst_i(rst), .pre_code_i(pre), .div_code_i(dv),
    .clk_en_i(en), .ddr_i(ddr), .card_clk_o(card_clk),
    .card_rise_o(card_rise), .card_stable_o(card_stable));

  function automatic int ref_ratio(logic [7:0] p, logic [3:0] d, logic dd);
    int b = -1;
    int pw;
    int n;
    for (int i = 0; i < 8; i++) if (p[i]) b = i;
    if (b < 0) pw = 1;
    else pw = dd ? (1 << b) : (1 << (b + 1));
    n = pw * (int'(d) + 1);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, one step per base clock
  always @(posedge clk) begin
    int nin;
    nin = ref_ratio(pre, dv, ddr);
    if (rst) begin
      m_run = 0; m_n = 2; m_pos = 0; m_clk = 0; m_rise = 0; m_stable = 0; m_per = 0;
    end else if (!en) begin
      m_run = 0; m_pos = 0; m_clk = 0; m_rise = 0; m_stable = 0; m_per = 0; m_n = nin;
    end else if (m_run == 0) begin
      m_run = 1; m_pos = 0; m_clk = 1; m_rise = 1; m_n = nin; m_per = 0; m_stable = 0;
    end else if (m_pos == m_n - 1) begin
      m_pos = 0; m_clk = 1; m_rise = 1;
      if (nin != m_n) begin
        m_n = nin; m_per = 0; m_stable = 0;
      end else begin
        if (m_per < 2) m_per++;
        m_stable = (m_per >= 2) ? 1 : 0;
      end
    end else begin
      m_pos++;
      m_clk = (m_pos < m_n / 2) ? 1 : 0;
      m_rise = 0;
      if (nin != m_n) m_stable = 0;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk(tag, "card_clk", int'(card_clk), m_clk);
      chk((tag == "R1") ? "R1" : "R6", "card_rise", int'(card_rise), m_rise);
      chk((tag == "R1") ? "R1" : "R10", "card_stable", int'(card_stable), m_stable);
    end
  end

  task automatic set(string t, logic [7:0] p, logic [3:0] d, logic e, logic dd);
    @(negedge clk);
    tag = t; pre = p; dv = d; en = e; ddr = dd;
  endtask

  task automatic run(int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    run(4);
    chk("R1", "reset card_clk", int'(card_clk), 0);
    chk("R1", "reset stable", int'(card_stable), 0);
    rst = 1'b0;
    set("R7", 8'h01, 4'h2, 1'b0, 1'b0); run(6);
    set("R4", 8'h00, 4'h0, 1'b1, 1'b0); run(20);
    set("R2", 8'h01, 4'h2, 1'b1, 1'b0); run(40);
    set("R2", 8'h05, 4'h0, 1'b1, 1'b0); run(60);
    set("R2", 8'h80, 4'hF, 1'b1, 1'b0); run(12400);
    set("R8", 8'h01, 4'h2, 1'b1, 1'b0); run(4200);
    run(40);
    set("R3", 8'h04, 4'h1, 1'b1, 1'b1); run(50);
    set("R5", 8'h01, 4'h4, 1'b1, 1'b1); run(50);
    set("R3", 8'h00, 4'h0, 1'b1, 1'b1); run(20);
    set("R9", 8'h01, 4'h2, 1'b1, 1'b0); run(31);
    set("R9", 8'h02, 4'h1, 1'b1, 1'b0);
    set("R9", 8'h01, 4'h2, 1'b1, 1'b0); run(40);
    set("R8", 8'h80, 4'hF, 1'b1, 1'b0); run(9000);
    set("R9", 8'h01, 4'h0, 1'b1, 1'b0);
    set("R9", 8'h80, 4'hF, 1'b1, 1'b0); run(4500);
    set("R6", 8'h02, 4'h2, 1'b1, 1'b0); run(60);
    set("R7", 8'h02, 4'h2, 1'b0, 1'b0); run(6);
    chk("R7", "disabled clk", int'(card_clk), 0);
    set("R7", 8'h02, 4'h2, 1'b1, 1'b0); run(2);
    set("R7", 8'h02, 4'h2, 1'b0, 1'b0); run(5);
    set("R10", 8'h01, 4'h1, 1'b1, 1'b0); run(60);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule